// File: doc/BRIEF.md
# Banked Level-Interrupt Combiner

This block folds a wide vector of level-sensitive interrupt sources into one request line per group of eight. Each group's line goes to a parent interrupt controller. The line is high while any source in the group is both active and enabled. Source levels are registered once on entry. Software clears an interrupt at the source, never inside the combiner.

Groups are packed four to a register bank. Each group owns one byte lane of a 32-bit word. Group g sits in bank g/4, lane g mod 4, at bits [(g mod 4)*8 +: 8], and bank b is decoded at byte address b*0x10. A bank has three registers:

- a write-one-to-enable register, which reads back the enable mask;
- a write-one-to-disable register;
- a read-only register that shows the raw source levels.

The number of groups is a parameter, 20 by default. When the group count is not a multiple of four, the unused lanes of the last bank read as zero.

Top module: `irq_combiner_banked`

## Requirements
- R1: Group output g is high exactly when (registered source level AND enable) is nonzero over byte lane g. A source change shows on the output after one clock edge.
- R2: Group g maps to bank g/4 at byte address (g/4)*0x10, bits [(g mod 4)*8 +: 8]. Enabling and driving one group's source raises that group's line only.
- R3: A write to bank offset 0x0 sets every enable bit whose data bit is 1 and leaves bits written 0 unchanged. A read of offset 0x0 returns the bank's enable mask.
- R4: A write to bank offset 0x4 clears every enable bit whose data bit is 1 and leaves the others unchanged. The affected group lines are low after that clock edge.
- R5: A read of bank offset 0xC returns the registered raw source levels of all four lanes, whatever the enables are. Writes to 0xC change nothing.
- R6: After reset, all enable bits are 0, all group lines are low and the read data is 0.
- R7: The following accesses are unmapped: offsets 0x4 (on reads) and 0x8, any address with a nonzero low two bits, and any bank index at or above the bank count. Unmapped reads return 0 and unmapped writes change nothing.
- R8: Sources are level-sensitive. A group line drops one edge after its active sources return low, with nothing latched.
- R9: The read data is registered. It updates on the edge that samples a read request and holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write request, one cycle per write |
| bus_rd | input | 1 | Read request, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_GROUPS*8 | Level interrupt sources, group g at [g*8 +: 8] |
| grp_irq | output | NUM_GROUPS | One combined request line per group |

## Verification
The latency rules are as follows:

- A write changes the enable mask on the edge that samples it, and the group lines reflect the new mask right after that edge.
- A source change reaches the status register and the group line one edge after it is driven.
- Read data is valid one edge after the read request.

The bench drives every input on a falling edge and samples on the next falling edge, so each result is observed exactly one rising edge after its stimulus. Before reading status, the bench waits one extra edge after changing the sources, so that the status register already holds them.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
    localparam int LANE_W        = 8;
    localparam int GRPS_PER_BANK = 4;
    localparam int BANK_W        = LANE_W * GRPS_PER_BANK;
    localparam int BANK_SPAN_LG2 = 4;

    localparam logic [3:0] OFS_EN_SET = 4'h0;
    localparam logic [3:0] OFS_EN_CLR = 4'h4;
    localparam logic [3:0] OFS_STATUS = 4'hC;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_STATUS
    } reg_sel_e;
endpackage

// File: rtl/cmb_addr_dec.sv
module cmb_addr_dec
    import cmb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 5,
    localparam int UP_W     = ADDR_W - BANK_SPAN_LG2,
    localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [BIDX_W-1:0] bank
);
    logic [UP_W-1:0] upper;
    logic            in_range;
    logic            aligned;

    always_comb begin
        upper    = addr[ADDR_W-1:BANK_SPAN_LG2];
        in_range = (32'(upper) < 32'(NUM_BANKS));
        aligned  = (addr[1:0] == 2'b00);
        bank     = BIDX_W'(upper);
        sel      = SEL_NONE;
        if (in_range && aligned) begin
            case (addr[BANK_SPAN_LG2-1:0])
                OFS_EN_SET: sel = SEL_EN_SET;
                OFS_EN_CLR: sel = SEL_EN_CLR;
                OFS_STATUS: sel = SEL_STATUS;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cmb_bank_regs.sv
module cmb_bank_regs
    import cmb_pkg::*;
#(
    parameter logic [BANK_W-1:0] LANE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] irq_lvl,
    output logic [BANK_W-1:0] en_q,
    output logic [BANK_W-1:0] stat_q
);
    typedef struct packed {
        logic [BANK_W-1:0] en;
        logic [BANK_W-1:0] stat;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = irq_lvl & LANE_MASK;
        if (set_we) begin
            st_d.en = st_d.en | wdata;
        end
        // a clear applied after a set in the same cycle takes precedence
        if (clr_we) begin
            st_d.en = st_d.en & ~wdata;
        end
        st_d.en = st_d.en & LANE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q   = st_q.en;
    assign stat_q = st_q.stat;
endmodule

// File: rtl/cmb_lane_reduce.sv
module cmb_lane_reduce
    import cmb_pkg::*;
#(
    parameter int NUM_LANES = GRPS_PER_BANK
) (
    input  logic [NUM_LANES*LANE_W-1:0] en,
    input  logic [NUM_LANES*LANE_W-1:0] stat,
    output logic [NUM_LANES-1:0]        lane_req
);
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_req[l] = |(en[l*LANE_W +: LANE_W] & stat[l*LANE_W +: LANE_W]);
    end
endmodule

// File: rtl/irq_combiner_banked.sv
module irq_combiner_banked
    import cmb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8,
    localparam int NUM_BANKS = (NUM_GROUPS + GRPS_PER_BANK - 1) / GRPS_PER_BANK,
    localparam int IN_W      = NUM_GROUPS * LANE_W,
    localparam int PAD_W     = NUM_BANKS * BANK_W,
    localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [IN_W-1:0]   irq_in,
    output logic [NUM_GROUPS-1:0] grp_irq
);
    reg_sel_e          sel;
    logic [BIDX_W-1:0] bank;
    logic [PAD_W-1:0]  irq_pad;
    logic [NUM_BANKS*GRPS_PER_BANK-1:0] grp_pad;
    logic [BANK_W-1:0] en_bank   [NUM_BANKS];
    logic [BANK_W-1:0] stat_bank [NUM_BANKS];

    assign irq_pad = PAD_W'(irq_in);

    cmb_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .bank (bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LANES_HERE = ((NUM_GROUPS - b*GRPS_PER_BANK) >= GRPS_PER_BANK)
                                    ? GRPS_PER_BANK : (NUM_GROUPS - b*GRPS_PER_BANK);
        localparam logic [BANK_W-1:0] MASK = (LANES_HERE == GRPS_PER_BANK)
                                    ? {BANK_W{1'b1}}
                                    : BANK_W'((64'd1 << (LANES_HERE*LANE_W)) - 64'd1);
        logic hit;
        assign hit = (32'(bank) == b);

        cmb_bank_regs #(
            .LANE_MASK (MASK)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_we  (bus_wr && hit && (sel == SEL_EN_SET)),
            .clr_we  (bus_wr && hit && (sel == SEL_EN_CLR)),
            .wdata   (bus_wdata),
            .irq_lvl (irq_pad[b*BANK_W +: BANK_W]),
            .en_q    (en_bank[b]),
            .stat_q  (stat_bank[b])
        );

        cmb_lane_reduce #(
            .NUM_LANES (GRPS_PER_BANK)
        ) u_red (
            .en       (en_bank[b]),
            .stat     (stat_bank[b]),
            .lane_req (grp_pad[b*GRPS_PER_BANK +: GRPS_PER_BANK])
        );
    end

    assign grp_irq = grp_pad[NUM_GROUPS-1:0];

    typedef struct packed {
        logic [31:0] rdata;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            case (sel)
                SEL_EN_SET: rd_d.rdata = en_bank[bank];
                SEL_STATUS: rd_d.rdata = stat_bank[bank];
                default:    rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;
endmodule

// File: rtl/cmb_checker.sv
module cmb_checker #(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8,
    localparam int NUM_BANKS = (NUM_GROUPS + 3) / 4,
    localparam int IN_W      = NUM_GROUPS * 8,
    localparam int PAD_W     = NUM_BANKS * 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [IN_W-1:0]   irq_in,
    input logic [NUM_GROUPS-1:0] grp_irq
);
    logic [1:0]       cyc_q;
    logic             set_seen_q;
    logic             unmapped;
    logic [PAD_W-1:0] pad;

    assign pad = PAD_W'(irq_in);

    always_comb begin
        unmapped = (bus_addr[3:0] != 4'h0 && bus_addr[3:0] != 4'hC)
                || (32'(bus_addr[ADDR_W-1:4]) >= 32'(NUM_BANKS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q      <= '0;
            set_seen_q <= 1'b0;
        end else begin
            if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
            if (bus_wr && bus_addr[3:0] == 4'h0 && bus_wdata != '0) set_seen_q <= 1'b1;
        end
    end

    AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && unmapped |=> bus_rdata == '0); // R7

    AST_QUIET_UNTIL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !set_seen_q |-> grp_irq == '0); // R6

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        AST_CLR_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
            bus_wr && bus_addr == ADDR_W'((g/4)*16 + 4) && (&bus_wdata[(g%4)*8 +: 8])
            |=> !grp_irq[g]); // R4

        AST_NO_SRC_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            !(|$past(irq_in[g*8 +: 8])) |-> !grp_irq[g]); // R8
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
        AST_STATUS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            cyc_q == 2'd3 && bus_rd && bus_addr == ADDR_W'(b*16 + 12)
            |=> bus_rdata == $past(pad[b*32 +: 32], 2)); // R5
    end
endmodule

bind irq_combiner_banked cmb_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .grp_irq   (grp_irq)
);

// File: tb/irq_combiner_banked_tb.sv
module irq_combiner_banked_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NG    = 20;
    localparam int NB    = 5;
    localparam int IW    = NG * 8;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [IW-1:0] irq_in = '0;
    logic [NG-1:0] grp_irq;

    logic [IW-1:0] en_m = '0;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_combiner_banked #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .grp_irq(grp_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [IW-1:0] act,
                       input logic [IW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NG-1:0] exp_grp();
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++) r[g] = |(irq_in[g*8 +: 8] & en_m[g*8 +: 8]);
        return r;
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drive(input logic [IW-1:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic en_set(input int b, input logic [31:0] d);
        wr(AW'(b*16), d);
        en_m[b*32 +: 32] = en_m[b*32 +: 32] | d;
    endtask

    task automatic en_clr(input int b, input logic [31:0] d);
        wr(AW'(b*16 + 4), d);
        en_m[b*32 +: 32] = en_m[b*32 +: 32] & ~d;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(grp_irq == '0, "R6 lines low", IW'(grp_irq), '0);
        chk(bus_rdata == '0, "R6 rdata", IW'(bus_rdata), '0);
        for (int b = 0; b < NB; b++) begin
            rd(AW'(b*16), d);
            chk(d == '0, "R6 enable zero", IW'(d), '0);
        end
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        en_set(1, 32'h00A5_0F00);
        rd(AW'(16), d);
        chk(d == 32'h00A5_0F00, "R3 set readback", IW'(d), IW'(32'h00A5_0F00));
        en_set(1, 32'h0);
        rd(AW'(16), d);
        chk(d == 32'h00A5_0F00, "R3 zero write keeps", IW'(d), IW'(32'h00A5_0F00));
        en_set(1, 32'h8000_0001);
        rd(AW'(16), d);
        chk(d == 32'h80A5_0F01, "R3 accumulate", IW'(d), IW'(32'h80A5_0F01));
        en_clr(1, 32'h0021_0300);
        rd(AW'(16), d);
        chk(d == 32'h8084_0C01, "R4 partial clear", IW'(d), IW'(32'h8084_0C01));
        en_clr(1, 32'hFFFF_FFFF);
        rd(AW'(16), d);
        chk(d == '0, "R4 full clear", IW'(d), '0);
    endtask

    task automatic t_mapping();
        logic [IW-1:0] v;
        en_set(3, 32'h0000_0400);
        v = '0; v[13*8 + 2] = 1'b1;
        drive(v);
        chk(grp_irq == NG'(1 << 13), "R2 group 13 only", IW'(grp_irq), IW'(1 << 13));
        v = '0; v[12*8 + 2] = 1'b1; v[14*8 + 2] = 1'b1;
        drive(v);
        chk(grp_irq == '0, "R2 neighbours idle", IW'(grp_irq), '0);
        en_clr(3, 32'hFFFF_FFFF);
    endtask

    task automatic t_combine();
        logic [31:0] lf = 32'hACE1_2345;
        logic [IW-1:0] v;
        for (int b = 0; b < NB; b++) en_set(b, 32'h5A3C_81F0 ^ (b * 32'h1111_1111));
        for (int it = 0; it < 8; it++) begin
            for (int w = 0; w < NB; w++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                v[w*32 +: 32] = lf & (it[0] ? 32'h0101_0101 : 32'hFFFF_FFFF);
            end
            drive(v);
            chk(grp_irq == exp_grp(), "R1 combine", IW'(grp_irq), IW'(exp_grp()));
        end
        drive('0);
        chk(grp_irq == '0, "R8 sources low", IW'(grp_irq), '0);
        en_clr(0, 32'h0000_00FF);
        drive({IW{1'b1}});
        chk(grp_irq[0] == 1'b0 && grp_irq == exp_grp(), "R4 cleared lane silent",
            IW'(grp_irq), IW'(exp_grp()));
    endtask

    task automatic t_status();
        logic [31:0] d;
        logic [IW-1:0] v;
        v = '0;
        v[2*32 +: 32] = 32'hDEAD_BEEF;
        en_clr(2, 32'hFFFF_FFFF);
        drive(v);
        rd(AW'(32 + 12), d);
        chk(d == 32'hDEAD_BEEF, "R5 raw status", IW'(d), IW'(32'hDEAD_BEEF));
        wr(AW'(32 + 12), 32'h0);
        rd(AW'(32 + 12), d);
        chk(d == 32'hDEAD_BEEF, "R5 status write ignored", IW'(d), IW'(32'hDEAD_BEEF));
        rd(AW'(32), d);
        chk(d == '0, "R5 status write no enable", IW'(d), '0);
        drive('0);
        chk(d == bus_rdata, "R9 rdata holds", IW'(bus_rdata), IW'(d));
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        logic [IW-1:0] saved;
        saved = en_m;
        wr(AW'(8), 32'hFFFF_FFFF);
        wr(AW'(16*5), 32'hFFFF_FFFF);
        wr(AW'(2), 32'hFFFF_FFFF);
        wr(AW'(16+1), 32'hFFFF_FFFF);
        for (int b = 0; b < NB; b++) begin
            rd(AW'(b*16), d);
            chk(d == saved[b*32 +: 32], "R7 write ignored", IW'(d), IW'(saved[b*32 +: 32]));
        end
        drive({IW{1'b1}});
        rd(AW'(12), d);
        chk(d == 32'hFFFF_FFFF, "R9 rdata loaded", IW'(d), IW'(32'hFFFF_FFFF));
        rd(AW'(8), d);
        chk(d == '0, "R7 read 0x8", IW'(d), '0);
        rd(AW'(4), d);
        chk(d == '0, "R7 read clear reg", IW'(d), '0);
        rd(AW'(16*5 + 12), d);
        chk(d == '0, "R7 bank out of range", IW'(d), '0);
        rd(AW'(13), d);
        chk(d == '0, "R7 misaligned", IW'(d), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_mapping();
        t_combine();
        t_status();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule